// File: doc/BRIEF.md
# Three-Link Doorbell Mailbox

This block lets a local processor and a remote processor signal each other over three fixed links. Each link carries two 32-bit doorbell words, one for each direction. The receive word carries remote-to-local traffic and the transmit word carries local-to-remote traffic. A sender raises bits by writing ones to a set register. The receiver reads the status word and drops the bits it has handled by writing ones to a clear register. A doorbell word that holds any set bit drives a level interrupt toward the side that consumes it.

No hardware signal reports that a transmission is complete. The sender polls its transmit status word until it reads back as zero, which happens once the remote has cleared it. The local side connects through a zero-wait APB slave. The remote processor uses a simple single-cycle register port with the same address map. The third link serves secure transactions only. The first two links are the low-priority and high-priority non-secure channels.

Top module: `doorbell_mailbox`

## Requirements
- R1: After reset every doorbell word reads zero and every interrupt output is low.
- R2: Writing a value to a set register ORs its one bits into the addressed doorbell word and leaves the other bits unchanged.
- R3: Writing a value to a clear register drops exactly its one bits from the addressed doorbell word.
- R4: loc_irq_o[n] is high exactly when the receive word of link n is nonzero. rmt_irq_o[n] is high exactly when the transmit word of link n is nonzero. Both change in the cycle after the write that alters the word.
- R5: Address map (byte offsets, 12-bit): the receive groups of links 0, 1 and 2 start at 0x000, 0x020 and 0x200. Each transmit group sits 0x100 above its receive group. Inside a group, status is at +0x0, set at +0x8 and clear at +0x10. Both ports use this same map.
- R6: Set and clear registers read as zero. Unmapped offsets read as zero. Writes to a status register or to an unmapped offset change nothing.
- R7: On the local port, an access with PPROT[1]=1 (non-secure) to any register of link 2 reads zero, has no effect and returns PSLVERR=1. Secure accesses to link 2, and all accesses to links 0 and 1, return PSLVERR=0.
- R8: When one port sets a bit and the other port clears the same bit of the same word in the same cycle, the bit ends up set.
- R9: The remote port has no security check. A transmit word raised by the local side returns to zero after the remote clears it, and the local side can observe this by polling.
- R10: The local port never inserts wait states (PREADY is always high), and a write takes effect on the clock edge that ends its access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | Local APB select |
| penable_i | input | 1 | Local APB enable (access phase) |
| pwrite_i | input | 1 | Local APB write strobe |
| paddr_i | input | ADDR_W | Local APB byte address |
| pwdata_i | input | DATA_W | Local APB write data |
| pprot_i | input | 3 | Local APB protection; bit 1 set means non-secure |
| prdata_o | output | DATA_W | Local APB read data |
| pready_o | output | 1 | Local APB ready, tied high |
| pslverr_o | output | 1 | Local APB error for a denied secure-link access |
| rmt_en_i | input | 1 | Remote port access strobe |
| rmt_we_i | input | 1 | Remote port write enable |
| rmt_addr_i | input | ADDR_W | Remote port byte address |
| rmt_wdata_i | input | DATA_W | Remote port write data |
| rmt_rdata_o | output | DATA_W | Remote port read data |
| loc_irq_o | output | NUM_LINKS | Per-link interrupt toward local side (receive word nonzero) |
| rmt_irq_o | output | NUM_LINKS | Per-link interrupt toward remote side (transmit word nonzero) |

## Verification
The bench builds the block with its defaults: 32-bit doorbell words, a 12-bit address and link 2 as the secure link. With these values the whole register map, including unmapped holes between groups, can be addressed by random draws. Every bit of each word can be raised and cleared from both ports. The single secure link also lets each combination of the protection bit and link be reached within a few hundred operations.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  localparam int NUM_LINKS  = 3;
  localparam int TX_OFS     = 'h100;
  localparam int REG_STRIDE = 'h8;

  typedef enum logic [1:0] {
    KIND_STAT = 2'd0,
    KIND_SET  = 2'd1,
    KIND_CLR  = 2'd2,
    KIND_NONE = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic      hit;
    logic [1:0] link;
    logic      dir;   // 0: receive word, 1: transmit word
    reg_kind_e kind;
  } reg_dec_t;

  function automatic int link_base(input int l);
    case (l)
      0:       return 'h000;
      1:       return 'h020;
      default: return 'h200;
    endcase
  endfunction
endpackage

// File: rtl/mbx_addr_decode.sv
`timescale 1ns/1ps
module mbx_addr_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_dec_t          dec_o
);
  always_comb begin
    dec_o      = '0;
    dec_o.kind = KIND_NONE;
    for (int l = 0; l < NUM_LINKS; l++) begin
      for (int d = 0; d < 2; d++) begin
        for (int k = 0; k < 3; k++) begin
          if (addr_i == ADDR_W'(link_base(l) + d * TX_OFS + k * 2 * REG_STRIDE / 2 * (k == 2 ? 1 : 1))) begin
            dec_o.hit  = 1'b1;
            dec_o.link = 2'(l);
            dec_o.dir  = (d == 1);
            dec_o.kind = reg_kind_e'(2'(k));
          end
        end
      end
    end
  end
endmodule

// File: rtl/mbx_wr_steer.sv
`timescale 1ns/1ps
module mbx_wr_steer
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                                   we_i,
  input  reg_dec_t                               dec_i,
  input  logic [DATA_W-1:0]                      data_i,
  output logic [1:0][NUM_LINKS-1:0][DATA_W-1:0]  set_o,
  output logic [1:0][NUM_LINKS-1:0][DATA_W-1:0]  clr_o
);
  for (genvar d = 0; d < 2; d++) begin : g_dir
    for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
      logic tgt;
      assign tgt = we_i && dec_i.hit && (dec_i.dir == (d == 1)) && (dec_i.link == 2'(l));
      assign set_o[d][l] = (tgt && dec_i.kind == KIND_SET) ? data_i : '0;
      assign clr_o[d][l] = (tgt && dec_i.kind == KIND_CLR) ? data_i : '0;
    end
  end
endmodule

// File: rtl/mbx_status_word.sv
`timescale 1ns/1ps
module mbx_status_word #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] stat_o,
  output logic              busy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else         stat_o <= (stat_o & ~clr_i) | set_i;  // set wins over clear
  end

  assign busy_o = |stat_o;
endmodule

// File: rtl/doorbell_mailbox.sv
`timescale 1ns/1ps
module doorbell_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  parameter int SEC_LINK = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 psel_i,
  input  logic                 penable_i,
  input  logic                 pwrite_i,
  input  logic [ADDR_W-1:0]    paddr_i,
  input  logic [DATA_W-1:0]    pwdata_i,
  input  logic [2:0]           pprot_i,
  output logic [DATA_W-1:0]    prdata_o,
  output logic                 pready_o,
  output logic                 pslverr_o,
  input  logic                 rmt_en_i,
  input  logic                 rmt_we_i,
  input  logic [ADDR_W-1:0]    rmt_addr_i,
  input  logic [DATA_W-1:0]    rmt_wdata_i,
  output logic [DATA_W-1:0]    rmt_rdata_o,
  output logic [NUM_LINKS-1:0] loc_irq_o,
  output logic [NUM_LINKS-1:0] rmt_irq_o
);
  typedef logic [1:0][NUM_LINKS-1:0][DATA_W-1:0] word_arr_t;

  reg_dec_t  loc_dec, rmt_dec;
  logic      loc_acc, loc_deny, loc_we, rmt_we;
  word_arr_t loc_set, loc_clr, rmt_set, rmt_clr, stat_q;
  logic [1:0][NUM_LINKS-1:0] busy;
  logic      unused_prot;

  assign unused_prot = pprot_i[0] ^ pprot_i[2];

  mbx_addr_decode #(.ADDR_W(ADDR_W)) i_loc_dec (.addr_i(paddr_i),    .dec_o(loc_dec));
  mbx_addr_decode #(.ADDR_W(ADDR_W)) i_rmt_dec (.addr_i(rmt_addr_i), .dec_o(rmt_dec));

  assign loc_acc  = psel_i && penable_i;
  assign loc_deny = loc_dec.hit && (loc_dec.link == 2'(SEC_LINK)) && pprot_i[1];
  assign loc_we   = loc_acc && pwrite_i && !loc_deny;
  assign rmt_we   = rmt_en_i && rmt_we_i;

  mbx_wr_steer #(.DATA_W(DATA_W)) i_loc_steer (
    .we_i(loc_we), .dec_i(loc_dec), .data_i(pwdata_i), .set_o(loc_set), .clr_o(loc_clr)
  );
  mbx_wr_steer #(.DATA_W(DATA_W)) i_rmt_steer (
    .we_i(rmt_we), .dec_i(rmt_dec), .data_i(rmt_wdata_i), .set_o(rmt_set), .clr_o(rmt_clr)
  );

  for (genvar d = 0; d < 2; d++) begin : g_dir
    for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
      mbx_status_word #(.DATA_W(DATA_W)) i_word (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (loc_set[d][l] | rmt_set[d][l]),
        .clr_i  (loc_clr[d][l] | rmt_clr[d][l]),
        .stat_o (stat_q[d][l]),
        .busy_o (busy[d][l])
      );
    end
  end

  assign loc_irq_o = busy[0];
  assign rmt_irq_o = busy[1];

  function automatic logic [DATA_W-1:0] rd_word(input reg_dec_t dec, input word_arr_t st);
    if (dec.hit && dec.kind == KIND_STAT && int'(dec.link) < NUM_LINKS)
      return st[dec.dir][dec.link];
    return '0;
  endfunction

  assign prdata_o    = (psel_i && !loc_deny) ? rd_word(loc_dec, stat_q) : '0;
  assign pready_o    = 1'b1;
  assign pslverr_o   = loc_acc && loc_deny;
  assign rmt_rdata_o = rd_word(rmt_dec, stat_q);
endmodule

// File: rtl/doorbell_mailbox_chk.sv
`timescale 1ns/1ps
module doorbell_mailbox_chk
  import mbx_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SEC_LINK = 2
) (
  input logic                                  clk_i,
  input logic                                  rst_ni,
  input logic                                  psel_i,
  input logic                                  penable_i,
  input logic                                  pwrite_i,
  input logic [2:0]                            pprot_i,
  input logic [DATA_W-1:0]                     pwdata_i,
  input logic                                  pslverr_o,
  input logic                                  rmt_en_i,
  input logic                                  rmt_we_i,
  input logic [DATA_W-1:0]                     rmt_wdata_i,
  input logic [NUM_LINKS-1:0]                  loc_irq_o,
  input logic [NUM_LINKS-1:0]                  rmt_irq_o,
  input reg_dec_t                              loc_dec,
  input reg_dec_t                              rmt_dec,
  input logic [1:0][NUM_LINKS-1:0][DATA_W-1:0] stat_q
);
  logic loc_wr, rmt_wr, loc_set_ok, clash;
  assign loc_wr     = psel_i && penable_i && pwrite_i;
  assign rmt_wr     = rmt_en_i && rmt_we_i;
  assign loc_set_ok = loc_wr && !pslverr_o && loc_dec.hit && loc_dec.kind == KIND_SET;
  assign clash      = loc_set_ok && rmt_wr && rmt_dec.hit && rmt_dec.kind == KIND_CLR &&
                      rmt_dec.dir == loc_dec.dir && rmt_dec.link == loc_dec.link;

  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (loc_irq_o == '0 && rmt_irq_o == '0));

  a_r7_err_only_nonsecure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && penable_i && pslverr_o) |-> pprot_i[1]);

  a_r7_secure_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_wr && pslverr_o && !rmt_en_i) |=>
      ($stable(stat_q[0][SEC_LINK]) && $stable(stat_q[1][SEC_LINK])));

  a_r2_set_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_set_ok && pwdata_i != '0) |=>
      ((stat_q[$past(loc_dec.dir)][$past(loc_dec.link)] & $past(pwdata_i)) == $past(pwdata_i)));

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clash |=> ((stat_q[$past(loc_dec.dir)][$past(loc_dec.link)] & $past(pwdata_i)) == $past(pwdata_i)));

  a_r6_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loc_wr && !rmt_wr) |=> $stable(stat_q));
endmodule

bind doorbell_mailbox doorbell_mailbox_chk #(.DATA_W(DATA_W), .SEC_LINK(SEC_LINK)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .psel_i(psel_i), .penable_i(penable_i),
  .pwrite_i(pwrite_i), .pprot_i(pprot_i), .pwdata_i(pwdata_i), .pslverr_o(pslverr_o),
  .rmt_en_i(rmt_en_i), .rmt_we_i(rmt_we_i), .rmt_wdata_i(rmt_wdata_i),
  .loc_irq_o(loc_irq_o), .rmt_irq_o(rmt_irq_o), .loc_dec(loc_dec), .rmt_dec(rmt_dec),
  .stat_q(stat_q)
);

// File: tb/test_doorbell_mailbox.sv
`timescale 1ns/1ps
module test_doorbell_mailbox;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int NL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [2:0] pprot = 3'b000;
  logic [DW-1:0] prdata;
  logic pready, pslverr;
  logic rmt_en = 1'b0, rmt_we = 1'b0;
  logic [AW-1:0] rmt_addr = '0;
  logic [DW-1:0] rmt_wdata = '0;
  logic [DW-1:0] rmt_rdata;
  logic [NL-1:0] loc_irq, rmt_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit [DW-1:0] exp_st [2][NL];

  always #2 clk = ~clk;  // 250 MHz

  doorbell_mailbox i_doorbell_mailbox (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .pprot_i(pprot), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .rmt_en_i(rmt_en), .rmt_we_i(rmt_we),
    .rmt_addr_i(rmt_addr), .rmt_wdata_i(rmt_wdata), .rmt_rdata_o(rmt_rdata),
    .loc_irq_o(loc_irq), .rmt_irq_o(rmt_irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int base_of(input int l);
    return (l == 0) ? 'h000 : (l == 1) ? 'h020 : 'h200;
  endfunction

  function automatic logic [AW-1:0] mk_addr(input int d, input int l, input int k);
    return AW'(base_of(l) + d * 'h100 + k * 'h8);
  endfunction

  // returns 0 for unmapped, else 1 with direction, link, kind (0 stat, 1 set, 2 clr)
  function automatic bit dec(input logic [AW-1:0] a, output int d, output int l, output int k);
    d = 0; l = 0; k = 0;
    for (int dd = 0; dd < 2; dd++)
      for (int ll = 0; ll < NL; ll++)
        for (int kk = 0; kk < 3; kk++)
          if (a == mk_addr(dd, ll, kk)) begin d = dd; l = ll; k = kk; return 1'b1; end
    return 1'b0;
  endfunction

  function automatic bit denied(input logic [AW-1:0] a, input logic [2:0] prot);
    int d, l, k;
    bit hit = dec(a, d, l, k);
    return hit && l == 2 && prot[1];
  endfunction

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    int d, l, k;
    if (dec(a, d, l, k) && k == 0) return exp_st[d][l];
    return '0;
  endfunction

  task automatic model_wr(input logic [AW-1:0] a, input logic [DW-1:0] v);
    int d, l, k;
    if (dec(a, d, l, k)) begin
      if (k == 1) exp_st[d][l] |= v;
      else if (k == 2) exp_st[d][l] &= ~v;
    end
  endtask

  task automatic chk_irq(input string req);
    for (int l = 0; l < NL; l++) begin
      chk({req, " loc_irq"}, DW'(loc_irq[l]), DW'(exp_st[0][l] != 0));
      chk({req, " rmt_irq"}, DW'(rmt_irq[l]), DW'(exp_st[1][l] != 0));
    end
  endtask

  task automatic apb_wr(input logic [AW-1:0] a, input logic [DW-1:0] v, input logic [2:0] prot,
                        input string req);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = v; pprot = prot;
    @(negedge clk);
    penable = 1'b1;
    #1;
    chk({req, " R10 pready"}, DW'(pready), 1);
    chk({req, " R7 pslverr wr"}, DW'(pslverr), DW'(denied(a, prot)));
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    if (!denied(a, prot)) model_wr(a, v);
    #1;
    chk_irq({req, " R4"});
  endtask

  task automatic apb_rd(input logic [AW-1:0] a, input logic [2:0] prot, input string req);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a; pprot = prot;
    @(negedge clk);
    penable = 1'b1;
    #1;
    chk({req, " R7 pslverr rd"}, DW'(pslverr), DW'(denied(a, prot)));
    chk({req, " rdata"}, prdata, denied(a, prot) ? '0 : exp_rd(a));
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rmt_wr(input logic [AW-1:0] a, input logic [DW-1:0] v, input string req);
    @(negedge clk);
    rmt_en = 1'b1; rmt_we = 1'b1; rmt_addr = a; rmt_wdata = v;
    @(negedge clk);
    rmt_en = 1'b0; rmt_we = 1'b0;
    model_wr(a, v);
    #1;
    chk_irq({req, " R4"});
  endtask

  task automatic rmt_rd(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    rmt_en = 1'b1; rmt_we = 1'b0; rmt_addr = a;
    #1;
    chk({req, " rmt rdata"}, rmt_rdata, exp_rd(a));
    @(negedge clk);
    rmt_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual expired expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int d = 0; d < 2; d++) for (int l = 0; l < NL; l++) exp_st[d][l] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk_irq("R1");
    for (int d = 0; d < 2; d++)
      for (int l = 0; l < NL; l++) apb_rd(mk_addr(d, l, 0), 3'b000, "R1");

    // R5: each link and direction at its own offset
    for (int l = 0; l < NL; l++) begin
      rmt_wr(mk_addr(0, l, 1), DW'(32'h11 << l), "R5");
      apb_wr(mk_addr(1, l, 1), DW'(32'h100 << l), 3'b000, "R5");
    end
    for (int d = 0; d < 2; d++)
      for (int l = 0; l < NL; l++) begin
        apb_rd(mk_addr(d, l, 0), 3'b000, "R5");
        rmt_rd(mk_addr(d, l, 0), "R5");
      end

    // R2/R3: set accumulates, clear drops exactly
    apb_wr(mk_addr(0, 0, 1), 32'hF0F0_0000, 3'b000, "R2");
    apb_rd(mk_addr(0, 0, 0), 3'b000, "R2");
    apb_wr(mk_addr(0, 0, 2), 32'h00F0_0011, 3'b000, "R3");
    apb_rd(mk_addr(0, 0, 0), 3'b000, "R3");

    // R6: set/clear read zero, status and unmapped writes ignored
    apb_rd(mk_addr(0, 0, 1), 3'b000, "R6");
    apb_rd(mk_addr(1, 1, 2), 3'b000, "R6");
    apb_wr(mk_addr(0, 1, 0), 32'hFFFF_FFFF, 3'b000, "R6");
    apb_wr(12'h004, 32'hFFFF_FFFF, 3'b000, "R6");
    apb_wr(12'h018, 32'hFFFF_FFFF, 3'b000, "R6");
    apb_rd(mk_addr(0, 1, 0), 3'b000, "R6");
    apb_rd(12'h004, 3'b000, "R6");

    // R7: non-secure access to secure link
    apb_wr(mk_addr(0, 2, 2), 32'hFFFF_FFFF, 3'b010, "R7");
    apb_wr(mk_addr(1, 2, 1), 32'h0000_FF00, 3'b010, "R7");
    apb_rd(mk_addr(0, 2, 0), 3'b010, "R7");
    apb_rd(mk_addr(0, 2, 0), 3'b000, "R7");
    apb_rd(mk_addr(0, 1, 0), 3'b010, "R7");
    apb_wr(mk_addr(0, 2, 2), 32'hFFFF_FFFF, 3'b000, "R7");
    apb_rd(mk_addr(0, 2, 0), 3'b000, "R7");

    // R8: simultaneous set (local) and clear (remote) on the same bits
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = mk_addr(1, 0, 1);
    pwdata = 32'h0000_0F0F; pprot = 3'b000;
    @(negedge clk);
    penable = 1'b1;
    rmt_en = 1'b1; rmt_we = 1'b1; rmt_addr = mk_addr(1, 0, 2); rmt_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; rmt_en = 1'b0; rmt_we = 1'b0;
    exp_st[1][0] = 32'h0000_0F0F;
    apb_rd(mk_addr(1, 0, 0), 3'b000, "R8");

    // R9: transmit done by polling after remote clears
    apb_wr(mk_addr(1, 1, 1), 32'h0000_0001, 3'b010, "R9");
    chk("R9 rmt_irq raised", DW'(rmt_irq[1]), 1);
    rmt_rd(mk_addr(1, 1, 0), "R9");
    rmt_wr(mk_addr(1, 1, 2), exp_st[1][1], "R9");
    apb_rd(mk_addr(1, 1, 0), 3'b010, "R9 poll zero");
    chk("R9 rmt_irq dropped", DW'(rmt_irq[1]), 0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 3);
      logic [AW-1:0] a;
      logic [DW-1:0] v = $urandom();
      logic [2:0] prot = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 7) == 0) a = AW'($urandom());
      else a = mk_addr($urandom_range(0, 1), $urandom_range(0, 2), $urandom_range(0, 2));
      if ($urandom_range(0, 1) == 0) v &= $urandom();
      case (op)
        0: apb_wr(a, v, prot, "R2 R3 rnd");
        1: apb_rd(a, prot, "R6 R7 rnd");
        2: rmt_wr(a, v, "R9 rnd");
        default: rmt_rd(a, "R9 rnd");
      endcase
    end

    // R1: reset clears everything again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int d = 0; d < 2; d++) for (int l = 0; l < NL; l++) exp_st[d][l] = '0;
    #1;
    chk_irq("R1 rereset");
    apb_rd(mk_addr(1, 2, 0), 3'b000, "R1 rereset");

    finish_run();
  end
endmodule